// File: doc/BRIEF.md
# Multi-format stereo audio serial transmitter

The block takes stereo PCM sample pairs from an ADC datapath and sends them as a serial bit stream on a three-wire audio link: a bit clock, a frame clock that marks the left and right halves of each sample period, and one data line. Three framings are supported: left-justified, right-justified and I2S. They differ only in where the word sits inside each half-frame relative to the frame clock edge. Data is always sent MSB first, with the left word in the first half-frame and the right word in the second.

As clock master, the block divides its system clock to produce the bit clock and counts bit clocks to produce the frame clock. As clock slave, it synchronises externally supplied bit and frame clocks into the system clock domain, finds their edges there, and drives only the data line. In both modes the data line changes just after a falling bit-clock edge, so it is stable at the rising edge where the receiver samples it.

Samples arrive as a 32-bit left/right pair on a valid/ready port. Back-pressure rules: `s_ready` is a one-cycle pulse issued once per frame, at the start of each left half-frame. The source keeps `s_valid` and both samples steady until it sees `s_valid` and `s_ready` high in the same cycle, and the pair is transferred at that clock edge. If `s_valid` is low during the pulse, the block sends the previous pair again and raises `underrun`. All `cfg_*` inputs are static and may change only while reset is held.

Top module: `aud_ser_tx`

## Requirements
- R1: With `cfg_master`=1, `clk_drive` is 1. `bclk_o` has a period of 2×`cfg_half` system clocks (`cfg_half` ≥ 2). Each half-frame holds exactly the configured number of bit clocks. `lrclk_o` changes only in the cycle where `bclk_o` falls.
- R2: With `cfg_master`=0, `clk_drive`, `bclk_o` and `lrclk_o` stay 0. The data stream follows `bclk_i`/`lrclk_i`, and a half-frame's length is the count of bit clocks between frame clock transitions.
- R3: With `cfg_fmt`=0 (left-justified), the frame clock is high for left. The MSB is on the first rising bit-clock edge after each frame clock transition.
- R4: With `cfg_fmt`=1 (right-justified), the frame clock is high for left. The LSB is on the last rising bit-clock edge before the next transition, and the earlier bits precede it MSB first.
- R5: With `cfg_fmt`=2 (I2S), the frame clock is low for left. The MSB is on the second rising edge after a transition. When the half-frame length equals the word length, the LSB falls on the first rising edge of the following half-frame.
- R6: `cfg_wlen` selects 16/20/24/32 bits for codes 0/1/2/3, and bits [31:32−W] of each sample are sent. `cfg_bpf` selects 16/24/32 bit clocks per half-frame for codes 0/1/2 (3 acts as 32) and must be ≥ W. The left word goes in the first half-frame and the right word in the second.
- R7: Every bit slot in a half-frame that holds no word bit carries 0.
- R8: `s_ready` is a single-cycle pulse at the start of each left half-frame. A pair transferred on that pulse is the one sent in the frame that begins there.
- R9: If `s_valid` is low during the `s_ready` pulse, the previous pair is repeated. `underrun` becomes 1 at that frame start and returns to 0 at the next frame start where a pair is transferred. It changes at no other time.
- R10: `sdata_o` changes only in the system clock cycle after a falling edge of the active bit clock, so it is stable at every rising edge.
- R11: During reset, `bclk_o`, `sdata_o`, `s_ready` and `underrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1 = clock master, 0 = clock slave |
| cfg_fmt | input | 2 | Framing: 0 left-justified, 1 right-justified, 2 I2S |
| cfg_wlen | input | 2 | Word length code: 16/20/24/32 bits |
| cfg_bpf | input | 2 | Bit clocks per half-frame code: 16/24/32 |
| cfg_half | input | DIV_W | System clocks per bit-clock phase in master mode (≥ 2) |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Pair accepted when high together with s_valid |
| s_left | input | SAMPLE_W | Left sample, MSB aligned |
| s_right | input | SAMPLE_W | Right sample, MSB aligned |
| bclk_i | input | 1 | External bit clock (slave mode) |
| lrclk_i | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| lrclk_o | output | 1 | Generated frame clock (master mode) |
| clk_drive | output | 1 | High when bclk_o/lrclk_o should drive the link |
| sdata_o | output | 1 | Serial data |
| underrun | output | 1 | Previous pair is being repeated |

## Verification
At the falling edge that opens a left half-frame, the new pair is latched from the handshake and, in I2S with a half-frame as long as the word, the right word's LSB of the old pair goes out in the same cycle. This is provoked by running I2S with half-frame lengths equal to 16, 24 and 32-bit words, in both clock modes, with a fresh pseudo-random pair on every transfer. The bench decodes each half-frame, including the bit that spills into the next half, and requires both the old right word and the newly latched left word to match the transferred pairs exactly. An underrun window in a master-mode run checks that a repeated pair and the `underrun` flag appear at the same frame boundary.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

  localparam int SLOT_W = 6;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_RJ  = 2'd1,
    FMT_I2S = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;

  function automatic logic [SLOT_W-1:0] word_len(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd20;
      2'd2:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] half_len(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  // frame clock level that marks the left half-frame
  function automatic logic left_level(input fmt_e fmt);
    return fmt != FMT_I2S;
  endfunction

endpackage

// File: rtl/aud_ser_clkgen.sv
module aud_ser_clkgen
  import aud_ser_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic [1:0]       cfg_fmt,
  input  logic [1:0]       cfg_bpf,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic             bclk_i,
  input  logic             lrclk_i,
  output logic             bclk_o,
  output logic             lrclk_o,
  output logic             src_bclk,
  output logic             src_lr
);

  localparam int FRAME_W = SLOT_W + 1;

  logic [DIV_W-1:0]   div_cnt;
  logic               bclk_q;
  logic [SLOT_W-1:0]  mslot;
  logic [SLOT_W-1:0]  mslot_nx;
  logic [SLOT_W-1:0]  hl;
  logic [FRAME_W-1:0] frame_last;
  logic               phase_end;
  logic               m_right;
  logic               lr_m;
  logic [1:0]         bclk_sync;
  logic [1:0]         lr_sync;
  fmt_e               fmt;

  assign fmt        = fmt_e'(cfg_fmt);
  assign hl         = half_len(cfg_bpf);
  assign frame_last = ({1'b0, hl} << 1) - FRAME_W'(1);
  assign phase_end  = div_cnt >= (cfg_half - DIV_W'(1));
  assign mslot_nx   = ({1'b0, mslot} >= frame_last) ? '0 : mslot + SLOT_W'(1);
  assign m_right    = mslot >= hl;
  assign lr_m       = m_right ^ left_level(fmt);

  // master divider and slot counter; slot advances on each falling phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      bclk_q  <= 1'b0;
      mslot   <= '1;
    end else if (!cfg_master) begin
      div_cnt <= '0;
      bclk_q  <= 1'b0;
      mslot   <= '1;
    end else if (phase_end) begin
      div_cnt <= '0;
      bclk_q  <= ~bclk_q;
      if (bclk_q) mslot <= mslot_nx;
    end else begin
      div_cnt <= div_cnt + DIV_W'(1);
    end
  end

  // two-stage synchronisers for slave clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_sync <= '0;
      lr_sync   <= '0;
    end else begin
      bclk_sync <= {bclk_sync[0], bclk_i};
      lr_sync   <= {lr_sync[0], lrclk_i};
    end
  end

  assign bclk_o   = cfg_master & bclk_q;
  assign lrclk_o  = cfg_master & lr_m;
  assign src_bclk = cfg_master ? bclk_q : bclk_sync[1];
  assign src_lr   = cfg_master ? lr_m   : lr_sync[1];

  // R1: generated frame clock only moves together with a bit clock fall
  a_r1_lr_on_bclk_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $changed(lrclk_o)) |-> $fell(bclk_o));

endmodule

// File: rtl/aud_ser_hold.sv
module aud_ser_hold #(
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          latch_ev,
  input  logic          in_valid,
  input  logic [SW-1:0] in_left,
  input  logic [SW-1:0] in_right,
  output logic          in_ready,
  output logic [SW-1:0] hold_l,
  output logic [SW-1:0] hold_r,
  output logic [SW-1:0] nxt_l,
  output logic [SW-1:0] nxt_r,
  output logic          underrun
);

  logic take;

  assign in_ready = latch_ev;
  assign take     = latch_ev & in_valid;
  assign nxt_l    = take ? in_left  : hold_l;
  assign nxt_r    = take ? in_right : hold_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l   <= '0;
      hold_r   <= '0;
      underrun <= 1'b0;
    end else if (latch_ev) begin
      hold_l   <= nxt_l;
      hold_r   <= nxt_r;
      underrun <= ~in_valid;
    end
  end

  // R8: the acceptance window is exactly one cycle wide
  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  // R9: underrun flag moves only at a frame boundary
  a_r9_underrun_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(underrun) |-> $past(in_ready));

  // R9: held pair keeps its value unless a transfer took place
  a_r9_hold_without_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && in_valid) |=> ($stable(hold_l) && $stable(hold_r)));

endmodule

// File: rtl/aud_ser_shifter.sv
module aud_ser_shifter
  import aud_ser_pkg::*;
#(
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_fmt,
  input  logic [1:0]    cfg_wlen,
  input  logic [1:0]    cfg_bpf,
  input  logic          src_bclk,
  input  logic          src_lr,
  input  logic [SW-1:0] hold_l,
  input  logic [SW-1:0] hold_r,
  input  logic [SW-1:0] nxt_l,
  input  logic [SW-1:0] nxt_r,
  output logic          latch_ev,
  output logic          sdata_o
);

  fmt_e              fmt;
  logic [SLOT_W-1:0] wl;
  logic [SLOT_W-1:0] hl;
  logic [SLOT_W-1:0] off;
  logic              bclk_d;
  logic              lr_prev;
  logic              locked;
  logic              in_right;
  logic [SLOT_W-1:0] slot;
  logic              fall;
  logic              lr_edge;
  logic              new_right;
  logic [SLOT_W-1:0] slot_nx;
  logic              right_nx;
  logic [SW-1:0]     word_nx;
  logic [SW-1:0]     word_prev;
  logic [SLOT_W-1:0] rel;
  logic [SW-1:0]     word_sh;
  logic [SW-1:0]     prev_sh;
  logic              spill;
  logic              in_word;
  logic              bit_nx;

  assign fmt = fmt_e'(cfg_fmt);
  assign wl  = word_len(cfg_wlen);
  assign hl  = half_len(cfg_bpf);

  // first word bit position inside a half-frame
  always_comb begin
    case (fmt)
      FMT_RJ:  off = hl - wl;
      FMT_I2S: off = SLOT_W'(1);
      default: off = '0;
    endcase
  end

  assign fall      = bclk_d & ~src_bclk;
  assign lr_edge   = locked & (src_lr != lr_prev);
  assign new_right = src_lr ^ left_level(fmt);
  assign latch_ev  = fall & lr_edge & ~new_right;

  assign slot_nx   = lr_edge ? '0 : ((&slot) ? slot : slot + SLOT_W'(1));
  assign right_nx  = lr_edge ? new_right : in_right;
  assign word_nx   = right_nx ? nxt_r : nxt_l;
  assign word_prev = new_right ? hold_l : hold_r;

  assign rel     = slot_nx - off;
  assign in_word = (slot_nx >= off) && (rel < wl);
  assign word_sh = word_nx << rel;
  assign prev_sh = word_prev << (wl - SLOT_W'(1));
  assign spill   = (fmt == FMT_I2S) && lr_edge && (hl == wl);

  always_comb begin
    if (spill)        bit_nx = prev_sh[SW-1];
    else if (in_word) bit_nx = word_sh[SW-1];
    else              bit_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d   <= 1'b0;
      lr_prev  <= 1'b0;
      locked   <= 1'b0;
      in_right <= 1'b0;
      slot     <= '1;
      sdata_o  <= 1'b0;
    end else begin
      bclk_d <= src_bclk;
      if (fall) begin
        lr_prev <= src_lr;
        if (!locked) begin
          locked   <= 1'b1;
          in_right <= new_right;
          slot     <= '1;
          sdata_o  <= 1'b0;
        end else begin
          in_right <= right_nx;
          slot     <= slot_nx;
          sdata_o  <= bit_nx;
        end
      end
    end
  end

  // R10: data line updates only right after a bit clock fall
  a_r10_data_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sdata_o) |-> $past(fall));

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_ser_pkg::*;
#(
  parameter int SAMPLE_W = 32,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_master,
  input  logic [1:0]          cfg_fmt,
  input  logic [1:0]          cfg_wlen,
  input  logic [1:0]          cfg_bpf,
  input  logic [DIV_W-1:0]    cfg_half,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  input  logic                bclk_i,
  input  logic                lrclk_i,
  output logic                bclk_o,
  output logic                lrclk_o,
  output logic                clk_drive,
  output logic                sdata_o,
  output logic                underrun
);

  logic                src_bclk;
  logic                src_lr;
  logic                latch_ev;
  logic [SAMPLE_W-1:0] hold_l;
  logic [SAMPLE_W-1:0] hold_r;
  logic [SAMPLE_W-1:0] nxt_l;
  logic [SAMPLE_W-1:0] nxt_r;

  assign clk_drive = cfg_master;

  aud_ser_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_master (cfg_master),
    .cfg_fmt    (cfg_fmt),
    .cfg_bpf    (cfg_bpf),
    .cfg_half   (cfg_half),
    .bclk_i     (bclk_i),
    .lrclk_i    (lrclk_i),
    .bclk_o     (bclk_o),
    .lrclk_o    (lrclk_o),
    .src_bclk   (src_bclk),
    .src_lr     (src_lr)
  );

  aud_ser_hold #(.SW(SAMPLE_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_ev (latch_ev),
    .in_valid (s_valid),
    .in_left  (s_left),
    .in_right (s_right),
    .in_ready (s_ready),
    .hold_l   (hold_l),
    .hold_r   (hold_r),
    .nxt_l    (nxt_l),
    .nxt_r    (nxt_r),
    .underrun (underrun)
  );

  aud_ser_shifter #(.SW(SAMPLE_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_fmt  (cfg_fmt),
    .cfg_wlen (cfg_wlen),
    .cfg_bpf  (cfg_bpf),
    .src_bclk (src_bclk),
    .src_lr   (src_lr),
    .hold_l   (hold_l),
    .hold_r   (hold_r),
    .nxt_l    (nxt_l),
    .nxt_r    (nxt_r),
    .latch_ev (latch_ev),
    .sdata_o  (sdata_o)
  );

endmodule

// File: tb/aud_ser_tx_tb.sv
module aud_ser_tx_tb;

  localparam int SLV_HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_master = 1'b1;
  logic [1:0]  cfg_fmt = 2'd0;
  logic [1:0]  cfg_wlen = 2'd0;
  logic [1:0]  cfg_bpf = 2'd0;
  logic [7:0]  cfg_half = 8'd2;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_left = '0;
  logic [31:0] s_right = '0;
  logic        bclk_i = 1'b0;
  logic        lrclk_i = 1'b0;
  logic        bclk_o, lrclk_o, clk_drive, sdata_o, underrun;

  always #5 clk = ~clk;

  aud_ser_tx u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_fmt(cfg_fmt),
    .cfg_wlen(cfg_wlen), .cfg_bpf(cfg_bpf), .cfg_half(cfg_half),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .bclk_i(bclk_i), .lrclk_i(lrclk_i), .bclk_o(bclk_o), .lrclk_o(lrclk_o),
    .clk_drive(clk_drive), .sdata_o(sdata_o), .underrun(underrun)
  );

  int n_vec = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // configuration mirrored in bench terms
  int m_wl, m_bpf, m_off, m_half;
  bit m_lh, m_i2s, m_master;

  // source side
  bit          src_en = 0, starve = 0, pend = 0;
  logic [31:0] lcg = 32'h1234_5678;
  logic [31:0] q_l[$], q_r[$];
  int          acc_cnt = 0;

  function automatic logic [31:0] step(input logic [31:0] x);
    return x * 32'd1664525 + 32'd1013904223;
  endfunction

  always @(negedge clk) begin
    if (src_en) begin
      if (pend) begin
        lcg = step(step(lcg));
        s_left = lcg;
        s_right = step(lcg) ^ 32'h5A3C_96E1;
        pend = 0;
      end
      if (s_valid && s_ready) begin
        q_l.push_back(s_left);
        q_r.push_back(s_right);
        acc_cnt++;
        pend = 1;
      end
      s_valid = !starve;
    end
  end

  // slave clock driver
  bit slv_en = 0;
  int scnt = 0, sslot = 0;
  initial forever begin
    @(posedge clk);
    #2;
    if (slv_en) begin
      scnt++;
      if (scnt >= SLV_HALF) begin
        scnt = 0;
        if (bclk_i) begin
          bclk_i = 1'b0;
          sslot = (sslot >= 2 * m_bpf - 1) ? 0 : sslot + 1;
          lrclk_i = (sslot >= m_bpf) ^ m_lh;
        end else begin
          bclk_i = 1'b1;
        end
      end
    end
  end

  // serial decoder
  bit          mon_en = 0, mb_prev = 0, sd_prev = 0, lr_init = 0, lr_p = 0;
  bit          have_rise = 0, frame_ok = 0, under_exp = 0, cur_right = 0;
  bit          bad_gap = 0, bad_stable = 0, bad_pins = 0;
  bit          arr[0:64];
  int          nb = 0, gap = 0, used = 0, frames_done = 0, saw_under = 0;
  logic [31:0] exp_l, exp_r;

  function automatic string fmt_tag();
    if (m_i2s) return "R5";
    if (m_off != 0 || cfg_fmt == 2'd1) return "R4";
    return "R3";
  endfunction

  task automatic finalize(input int n, input bit right);
    logic [31:0] w, e;
    bit idle_bad;
    if (!frame_ok) return;
    chk(n == m_bpf, m_master ? "R1 half-frame length" : "R2 half-frame length", n, m_bpf);
    w = '0;
    for (int j = 0; j < m_wl; j++) w = {w[30:0], arr[m_off + j]};
    e = (right ? exp_r : exp_l) >> (32 - m_wl);
    chk(w == e, right ? {fmt_tag(), " R6 right word"} : {fmt_tag(), " R6 left word"}, w, e);
    idle_bad = 0;
    for (int p = 0; p < m_bpf; p++)
      if ((p < m_off || p >= m_off + m_wl) && !(m_i2s && p == 0) && arr[p]) idle_bad = 1;
    chk(!idle_bad, "R7 idle slots zero", idle_bad, 0);
    if (right) frames_done++;
  endtask

  always @(negedge clk) begin
    bit mb, ml, sd, nr;
    if (mon_en) begin
      mb = m_master ? bclk_o : bclk_i;
      ml = m_master ? lrclk_o : lrclk_i;
      sd = sdata_o;
      gap++;
      if (!m_master && (bclk_o || lrclk_o || clk_drive)) bad_pins = 1;
      if (mb && !mb_prev) begin
        if (sd != sd_prev) bad_stable = 1;
        if (m_master && have_rise && gap != 2 * m_half) bad_gap = 1;
        have_rise = 1;
        gap = 0;
        if (!lr_init) begin
          lr_init = 1;
          lr_p = ml;
          nb = 1;
        end else if (ml != lr_p) begin
          arr[nb > 64 ? 64 : nb] = sd;
          finalize(nb, cur_right);
          lr_p = ml;
          nr = ml ^ m_lh;
          if (!nr) begin
            if (used < acc_cnt) begin
              exp_l = q_l[used];
              exp_r = q_r[used];
              used++;
              frame_ok = 1;
              under_exp = 0;
            end else begin
              under_exp = frame_ok;
            end
            if (frame_ok) begin
              chk(underrun == under_exp, "R9 underrun flag", underrun, under_exp);
              if (under_exp) saw_under++;
            end
          end
          arr[0] = sd;
          nb = 1;
          cur_right = nr;
        end else begin
          if (nb <= 64) arr[nb] = sd;
          nb++;
        end
      end
      mb_prev = mb;
      sd_prev = sd;
    end
  end

  task automatic run_cfg(input bit master, input int fmt, input int wlc, input int bpfc,
                         input int half, input int nfr, input bit with_starve);
    @(posedge clk); #1;
    rst_n = 1'b0;
    src_en = 0; mon_en = 0; slv_en = 0; starve = 0; pend = 0;
    s_valid = 1'b0;
    bclk_i = 1'b0;
    cfg_master = master;
    cfg_fmt = 2'(fmt);
    cfg_wlen = 2'(wlc);
    cfg_bpf = 2'(bpfc);
    cfg_half = 8'(half);
    m_master = master;
    m_half = half;
    m_wl = (wlc == 0) ? 16 : (wlc == 1) ? 20 : (wlc == 2) ? 24 : 32;
    m_bpf = (bpfc == 0) ? 16 : (bpfc == 1) ? 24 : 32;
    m_i2s = (fmt == 2);
    m_lh = !m_i2s;
    m_off = (fmt == 1) ? m_bpf - m_wl : (fmt == 2) ? 1 : 0;
    sslot = 2 * m_bpf - 1;
    scnt = 0;
    lrclk_i = 1'b1 ^ m_lh;
    q_l.delete(); q_r.delete();
    acc_cnt = 0; used = 0; frames_done = 0; saw_under = 0;
    lr_init = 0; mb_prev = 0; sd_prev = 0; have_rise = 0; frame_ok = 0; gap = 0; nb = 0;
    bad_gap = 0; bad_stable = 0; bad_pins = 0;
    lcg = step(lcg ^ 32'(fmt * 97 + wlc * 13 + bpfc));
    s_left = lcg;
    s_right = ~lcg;
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    src_en = 1; mon_en = 1; slv_en = !master;
    while (frames_done < nfr) begin
      @(posedge clk);
      if (with_starve) starve = (frames_done >= 2 && frames_done < 4);
    end
    starve = 0;
    if (master) chk(!bad_gap && clk_drive, "R1 bit clock period", bad_gap, 0);
    else        chk(!bad_pins, "R2 clock pins held low", bad_pins, 0);
    chk(!bad_stable, "R10 data stable at rising edge", bad_stable, 0);
    if (with_starve) chk(saw_under > 0, "R9 repeated frame seen", saw_under, 1);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #4;
    // R11: outputs quiet under reset
    chk(bclk_o == 1'b0 && sdata_o == 1'b0, "R11 reset clock/data", {bclk_o, sdata_o}, 0);
    chk(s_ready == 1'b0 && underrun == 1'b0, "R11 reset ready/underrun", {s_ready, underrun}, 0);
    for (int md = 1; md >= 0; md--)
      for (int f = 0; f < 3; f++)
        for (int w = 0; w < 4; w++)
          for (int b = 0; b < 3; b++) begin
            int wb, bb;
            wb = (w == 0) ? 16 : (w == 1) ? 20 : (w == 2) ? 24 : 32;
            bb = (b == 0) ? 16 : (b == 1) ? 24 : 32;
            if (bb >= wb) run_cfg(md[0], f, w, b, 2, 3, 0);
          end
    run_cfg(1, 0, 0, 0, 3, 3, 0);
    run_cfg(1, 2, 2, 1, 5, 3, 0);
    run_cfg(1, 0, 2, 2, 2, 7, 1);
    run_cfg(1, 2, 3, 2, 2, 7, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule